// File: doc/BRIEF.md
# Seven-to-one pixel lane serializer

This block turns one parallel pixel (8-bit red, green and blue, plus data-enable, horizontal sync and vertical sync) into four 7-bit frames, one per data lane, and shifts them out most-significant position first, one bit per cycle of the bit-rate clock. A fifth output, the clock lane, repeats a fixed 7-bit pattern in step with the frames. A downstream differential driver would sit on every output.

The pixel source raises a one-cycle strobe in the bit-clock domain for each new pixel. The pixel is captured into a holding register and moved into the lane shift registers only at a frame boundary, so one frame always carries one pixel. If no new pixel arrives, the held pixel is sent again. A two-bit mode input picks one of three lane layouts: 18-bit colour on three lanes, 24-bit colour with the low two bits of each colour on the fourth lane (the first three lanes then look exactly like 18-bit mode), or 24-bit colour with the high two bits of each colour on the fourth lane.

Top module: `lvds_pixel_serializer`

## Requirements
- R1: From reset until the first frame is loaded, all four data lanes and the clock lane output 0.
- R2: A pixel is captured at the clock edge where `pix_stb` is high. When the serializer is idle, the first bit of that pixel's frame appears on the outputs after the next clock edge.
- R3: Once started, frames follow each other without gaps. Each frame is exactly 7 bit cycles long.
- R4: A strobe that falls on the same edge as a frame load does not change the frame being loaded. That frame carries the previously held pixel, and the new pixel goes out in the frame after it.
- R5: In every frame the clock lane sends 1,1,0,0,0,1,1 from the first bit onward. Its edges therefore sit 2 bit periods after the frame boundary.
- R6: With `map_mode`=0 (18-bit), bits are sent in frame order as follows. Lane 0 sends G2,R7,R6,R5,R4,R3,R2. Lane 1 sends B3,B2,G7,G6,G5,G4,G3. Lane 2 sends DE,VSYNC,HSYNC,B7,B6,B5,B4. Lane 3 stays at 0.
- R7: With `map_mode`=1 (24-bit compatible), lanes 0 to 2 are identical to R6. Lane 3 sends 0,B1,B0,G1,G0,R1,R0.
- R8: With `map_mode`=2 or 3 (24-bit standard), bits are sent in frame order as follows. Lane 0 sends G0,R5..R0. Lane 1 sends B1,B0,G5..G1. Lane 2 sends DE,VSYNC,HSYNC,B5..B2. Lane 3 sends 0,B7,B6,G7,G6,R7,R6.
- R9: The first bit of every frame on lane 3 is the spare bit and is always 0.
- R10: Without a new strobe, the holding register keeps its pixel, and every later frame repeats it.
- R11: `map_mode` is sampled only at the frame load. A change part-way through a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock (seven times the pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | One-cycle strobe marking a new pixel |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_de | input | 1 | Data enable |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| map_mode | input | 2 | Lane layout: 0 18-bit, 1 24-bit compatible, 2/3 24-bit standard |
| lane_data | output | 4 | Serial bit of data lanes 3..0 |
| lane_clk | output | 1 | Serial bit of the clock lane |

## Verification
A pixel capture and a frame load can happen on the same edge. The strobe is then written into the holding register while that register is copied into the shift registers. The bench places the strobe at every position of the frame, including the last bit (the colliding case) and leaving it out entirely. It also moves the mode input in the middle of a frame. An arithmetic model of the holding register predicts which pixel and which layout each frame must carry: for a collision it expects the old pixel repeated once and then the new one, and every bit position of every lane is compared against that prediction.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

  localparam int unsigned FRAME_BITS = 7;
  localparam int unsigned DATA_LANES = 4;
  localparam int unsigned COLOR_W    = 8;

  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef enum logic [1:0] {
    MAP_18        = 2'd0,
    MAP_24_COMPAT = 2'd1,
    MAP_24_STD    = 2'd2,
    MAP_24_STD_B  = 2'd3
  } map_e;

  typedef struct packed {
    logic               de;
    logic               vs;
    logic               hs;
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
  } pix_t;

  // Frame vector: bit FRAME_BITS-1 is transmitted first.
  function automatic frame_t pack_lane(map_e m, pix_t p, int unsigned lane);
    frame_t f;
    logic   std;
    std = (m == MAP_24_STD) || (m == MAP_24_STD_B);
    f   = '0;
    case (lane)
      0: f = std ? {p.g[0], p.r[5:0]} : {p.g[2], p.r[7:2]};
      1: f = std ? {p.b[1:0], p.g[5:1]} : {p.b[3:2], p.g[7:3]};
      2: f = std ? {p.de, p.vs, p.hs, p.b[5:2]} : {p.de, p.vs, p.hs, p.b[7:4]};
      3: begin
        if (m == MAP_18) f = '0;
        else if (std)    f = {1'b0, p.b[7:6], p.g[7:6], p.r[7:6]};
        else             f = {1'b0, p.b[1:0], p.g[1:0], p.r[1:0]};
      end
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pix_holder.sv
module pix_holder
  import lvds_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  pix_t pix_i,
  output pix_t hold_o,
  output logic valid_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_o  <= '0;
      valid_o <= 1'b0;
    end else if (stb_i) begin
      hold_o  <= pix_i;
      valid_o <= 1'b1;
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> (hold_o == $past(pix_i)));

  p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> (hold_o == $past(hold_o)));

endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned FRAME_LEN = 7,
  localparam int unsigned PW = $clog2(FRAME_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  output logic          load_o,
  output logic          run_o,
  output logic [PW-1:0] pos_o
);

  localparam logic [PW-1:0] LAST = PW'(FRAME_LEN - 1);

  assign load_o = run_o ? (pos_o == LAST) : valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_o <= 1'b0;
      pos_o <= '0;
    end else if (load_o) begin
      run_o <= 1'b1;
      pos_o <= '0;
    end else if (run_o) begin
      pos_o <= pos_o + 1'b1;
    end
  end

  p_frame_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (run_o && pos_o == '0));

  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |=> run_o);

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int unsigned FRAME_LEN = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  output logic                 bit_o
);

  logic [FRAME_LEN-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n)       sreg <= '0;
    else if (load_i)  sreg <= frame_i;
    else if (shift_i) sreg <= {sreg[FRAME_LEN-2:0], 1'b0};
  end

  assign bit_o = sreg[FRAME_LEN-1];

  p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (bit_o == $past(frame_i[FRAME_LEN-1])));

endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
  import lvds_ser_pkg::*;
#(
  parameter logic [FRAME_BITS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_stb,
  input  logic [COLOR_W-1:0]    pix_r,
  input  logic [COLOR_W-1:0]    pix_g,
  input  logic [COLOR_W-1:0]    pix_b,
  input  logic                  pix_de,
  input  logic                  pix_hs,
  input  logic                  pix_vs,
  input  logic [1:0]            map_mode,
  output logic [DATA_LANES-1:0] lane_data,
  output logic                  lane_clk
);

  localparam int unsigned PW = $clog2(FRAME_BITS);

  pix_t          pix_in;
  pix_t          hold;
  logic          hold_valid;
  logic          frame_load;
  logic          running;
  logic [PW-1:0] bit_pos;
  map_e          mode_now;
  map_e          cur_mode;

  assign pix_in   = '{de: pix_de, vs: pix_vs, hs: pix_hs, r: pix_r, g: pix_g, b: pix_b};
  assign mode_now = map_e'(map_mode);

  pix_holder u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (pix_stb),
    .pix_i  (pix_in),
    .hold_o (hold),
    .valid_o(hold_valid)
  );

  frame_timer #(.FRAME_LEN(FRAME_BITS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(hold_valid),
    .load_o (frame_load),
    .run_o  (running),
    .pos_o  (bit_pos)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)          cur_mode <= MAP_18;
    else if (frame_load) cur_mode <= mode_now;
  end

  for (genvar ln = 0; ln < DATA_LANES; ln++) begin : g_lane
    frame_t lane_frame;
    assign lane_frame = pack_lane(mode_now, hold, ln);

    lane_shifter #(.FRAME_LEN(FRAME_BITS)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (frame_load),
      .shift_i(running),
      .frame_i(lane_frame),
      .bit_o  (lane_data[ln])
    );
  end

  lane_shifter #(.FRAME_LEN(FRAME_BITS)) u_clk_lane (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (frame_load),
    .shift_i(running),
    .frame_i(CLK_PATTERN),
    .bit_o  (lane_clk)
  );

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (lane_data == '0 && !lane_clk));

  p_clk_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> lane_clk);

  p_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bit_pos == PW'(2)) |-> !lane_clk);

  p_lane3_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cur_mode == MAP_18) |-> !lane_data[3]);

  p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_load) |-> !lane_data[3]);

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(cur_mode));

endmodule

// File: tb/tb_lvds_pixel_serializer.sv
module tb_lvds_pixel_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_stb = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic       pix_de = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
  logic [1:0] map_mode = 2'd0;
  logic [3:0] lane_data;
  logic       lane_clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lvds_pixel_serializer dut (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .map_mode(map_mode), .lane_data(lane_data), .lane_clk(lane_clk)
  );

  // word layout: [26]=de [25]=vs [24]=hs [23:16]=R [15:8]=G [7:0]=B
  function automatic logic [26:0] gen_pix(int n);
    logic [7:0] r, g, b;
    if (n < 27) return 27'(1) << n;
    r = 8'(n * 37 + 5);
    g = 8'(n * 101) ^ 8'h5a;
    b = ~8'(n * 13);
    return {n[0], n[1] ^ n[3], n[2], r, g, b};
  endfunction

  function automatic logic exp_bit(int m, logic [26:0] w, int lane, int pos);
    logic [7:0] r, g, b;
    bit std;
    r = w[23:16]; g = w[15:8]; b = w[7:0];
    std = (m >= 2);
    if (lane == 2 && pos < 3) return w[26 - pos];
    if (lane == 3) begin
      if (m == 0 || pos == 0) return 1'b0;
      if (pos <= 2) return std ? b[8 - pos] : b[2 - pos];
      if (pos <= 4) return std ? g[10 - pos] : g[4 - pos];
      return std ? r[12 - pos] : r[6 - pos];
    end
    if (lane == 0) begin
      if (pos == 0) return std ? g[0] : g[2];
      return std ? r[6 - pos] : r[8 - pos];
    end
    if (lane == 1) begin
      if (pos < 2) return std ? b[1 - pos] : b[3 - pos];
      return std ? g[7 - pos] : g[9 - pos];
    end
    return std ? b[8 - pos] : b[10 - pos];
  endfunction

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic drive_pix(input logic [26:0] w);
    {pix_de, pix_vs, pix_hs, pix_r, pix_g, pix_b} = w;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [26:0] shown, hold_m, nxt;
    int shown_mode, mode_in, stb_pos;
    string tag, prev_kind;
    localparam int NFR = 160;

    // R1: idle outputs during and after reset
    repeat (3) @(negedge clk);
    chk({lane_data, lane_clk}, 5'b0, "R1 in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk({lane_data, lane_clk}, 5'b0, "R1 idle after reset");
    end

    mode_in = 0; map_mode = 2'd0;
    hold_m = gen_pix(0);
    drive_pix(hold_m);
    pix_stb = 1'b1;
    @(negedge clk);
    pix_stb = 1'b0;
    chk({lane_data, lane_clk}, 5'b0, "R2 nothing before load");
    shown = hold_m; shown_mode = 0; prev_kind = "R2";

    for (int n = 0; n < NFR; n++) begin
      int target;
      target = n / 40;
      stb_pos = (n == NFR - 1) ? 7 : ((n % 9 == 8) ? 2 : n % 9);
      nxt = gen_pix(n + 1);
      for (int pos = 0; pos < 7; pos++) begin
        logic [4:0] e;
        @(negedge clk);
        for (int ln = 0; ln < 4; ln++) e[ln + 1] = exp_bit(shown_mode, shown, ln, pos);
        e[0] = (pos < 2 || pos > 4);
        if (prev_kind != "") tag = prev_kind;
        else tag = (shown_mode == 0) ? "R6" : (shown_mode == 1) ? "R7" : "R8";
        chk({lane_data, 1'b0}, {e[4:1], 1'b0}, tag);
        chk({4'b0, lane_clk}, {4'b0, e[0]}, (pos == 0) ? "R3" : "R5");
        if (pos == 0 && shown_mode != 0) chk({lane_data[3], 4'b0}, 5'b0, "R9");
        pix_stb = (pos == stb_pos);
        if (pos == stb_pos) drive_pix(nxt);
        if (pos == 3 && mode_in != target) begin
          mode_in = target;
          map_mode = 2'(target);
        end
      end
      prev_kind = "";
      if (shown_mode != mode_in) prev_kind = "R11";
      if (stb_pos <= 5) begin
        hold_m = nxt; shown = hold_m;
      end else if (stb_pos == 6) begin
        shown = hold_m; hold_m = nxt; prev_kind = "R4";
      end else begin
        shown = hold_m; prev_kind = "R10";
      end
      shown_mode = mode_in;
    end
    @(negedge clk);
    pix_stb = 1'b0;

    // R1: reset mid-stream returns all lanes to 0
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk({lane_data, lane_clk}, 5'b0, "R1 idle after re-reset");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule